// File: doc/BRIEF.md
# Priority-Masked Interrupt Controller

This block gathers interrupt requests from a parameterised set of peripheral sources, picks the most urgent pending one and raises one request line toward the CPU. Each source has a request flag and a 3-bit priority level. Lower level values are more urgent. A level of 7 turns the source off. The most urgent pending source is compared against a 3-bit mask level held for the CPU. The CPU request is raised only when that mask is strictly greater than the winning level.

Sources come in pairs, and each pair shares one 16-bit control word that software reads and writes over a simple synchronous register port. A source can be one of two kinds. An edge-type source has a sticky flag: the peripheral sets it, and software can set or clear it. A level-type source has a read-only flag that follows its request line. The CPU interacts through two strobes. Reading the vector returns the index of the winning source and clears that source's sticky flag. Writing the mask loads a new mask level. Either strobe drops the CPU request, and the request is re-armed one clock later if a source still qualifies.

Top module: `irq_ctrl`

## Requirements
- R1: A synchronous reset clears every edge-type flag, the mask register and `cpu_irq`, and sets every level field to 7. After reset, each control word reads `16'hE0E0` while no level-type request is active.
- R2: A source whose level is 7 never wins arbitration and never causes `cpu_irq`, even while its flag is set.
- R3: A pending winner of level L sets `cpu_irq` only when the mask value is at least L+1. This means level 6 needs a mask of 7, and a mask of 0 blocks every source.
- R4: Among pending, enabled sources, the lowest level wins, and equal levels go to the lowest source index. `vec_idx` shows the winner's index combinationally.
- R5: An edge-type flag is set on any clock edge where its `src_req` bit is high, and it stays set after the request drops. A peripheral set takes precedence over a software clear or a vector-read clear in the same cycle.
- R6: In control word k, source 2k uses bit 3 (flag) and bits 7:5 (level), and source 2k+1 uses bit 11 (flag) and bits 15:13 (level). All other bits read 0. A write updates both levels and the edge-type flags of that word on the next edge.
- R7: The flag of a level-type source reads as its current `src_req` bit, and register writes do not change it.
- R8: `cpu_irq` is registered and sticky. It is 0 in the cycle after a `vec_rd` or `mask_wr` strobe. With no strobe, it is set on the first edge where the winner qualifies under the current mask.
- R9: A `vec_rd` strobe clears the sticky flag of the current winner only if that winner is an edge-type source. All other flags are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 2*NUM_WORDS | Request line from each source |
| reg_wr | input | 1 | Control-word write strobe |
| reg_addr | input | AW | Control-word index for write and read |
| reg_wdata | input | 16 | Control-word write data |
| reg_rdata | output | 16 | Addressed control word (combinational) |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 3 | New mask level |
| vec_rd | input | 1 | Vector read strobe |
| vec_idx | output | IW | Index of the current winning source |
| cpu_irq | output | 1 | Interrupt request to the CPU |

## Verification
The following properties are checked on every cycle:
- No level-7 source is ever reported as the winner.
- Every rising `cpu_irq` is preceded by a winner whose level was below the mask.
- Either strobe forces `cpu_irq` low on the next cycle.
- An active request always leaves an edge-type flag set.
- Reset returns level fields to 7.

Other behaviours only show up in the bench scenarios, where a reference model runs alongside the design:
- tie-breaking among equal levels;
- the exact bit layout of the control word;
- writes being ignored on level-type flags;
- a vector read clearing only the winner;
- re-arming after a strobe.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int LVL_W    = 3;
    localparam int WORD_W   = 16;
    localparam int SLOT_W   = 8;
    localparam int FLAG_BIT = 3;
    localparam int LVL_LSB  = 5;

    typedef logic [LVL_W-1:0] lvl_t;
    localparam lvl_t LVL_OFF = 3'd7;

    typedef struct packed {
        logic pend;
        lvl_t lvl;
    } src_stat_t;

    function automatic logic slot_flag(input logic [WORD_W-1:0] w, input int slot);
        return w[slot*SLOT_W + FLAG_BIT];
    endfunction

    function automatic lvl_t slot_lvl(input logic [WORD_W-1:0] w, input int slot);
        return w[slot*SLOT_W + LVL_LSB +: LVL_W];
    endfunction

    function automatic logic [SLOT_W-1:0] pack_slot(input logic flag, input lvl_t lvl);
        return {lvl, 1'b0, flag, 3'b000};
    endfunction
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import irq_pkg::*;
#(
    parameter bit LEVEL_TYPE = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      req,
    input  logic      wr_en,
    input  logic      wr_flag,
    input  lvl_t      wr_lvl,
    input  logic      vec_clr,
    output logic      flag,
    output lvl_t      lvl,
    output src_stat_t stat
);
    lvl_t lvl_q;

    always_ff @(posedge clk) begin
        if (rst)        lvl_q <= LVL_OFF;
        else if (wr_en) lvl_q <= wr_lvl;
    end

    generate
        if (LEVEL_TYPE) begin : g_level
            logic unused_ins;
            assign unused_ins = wr_flag ^ vec_clr;
            assign flag = req;
        end else begin : g_edge
            logic flag_q;
            always_ff @(posedge clk) begin
                if (rst)          flag_q <= 1'b0;
                else if (req)     flag_q <= 1'b1;
                else if (wr_en)   flag_q <= wr_flag;
                else if (vec_clr) flag_q <= 1'b0;
            end
            assign flag = flag_q;

            p_edge_set_r5: assert property (@(posedge clk) disable iff (rst)
                req |=> flag_q);
        end
    endgenerate

    assign lvl  = lvl_q;
    assign stat = '{pend: flag, lvl: lvl_q};

    p_lvl_reset_r1: assert property (@(posedge clk) rst |=> (lvl_q == LVL_OFF));
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
    import irq_pkg::*;
#(
    parameter int N  = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  src_stat_t         stat [N],
    output logic              win_valid,
    output logic [IW-1:0]     win_idx,
    output lvl_t              win_lvl
);
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_lvl   = LVL_OFF;
        for (int i = 0; i < N; i++) begin
            if (stat[i].pend && (stat[i].lvl < win_lvl)) begin
                win_valid = 1'b1;
                win_idx   = IW'(i);
                win_lvl   = stat[i].lvl;
            end
        end
    end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    parameter logic [2*NUM_WORDS-1:0] LEVEL_SRC = 8'hC0,
    localparam int N  = 2 * NUM_WORDS,
    localparam int AW = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      src_req,
    input  logic              reg_wr,
    input  logic [AW-1:0]     reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              mask_wr,
    input  logic [2:0]        mask_wdata,
    input  logic              vec_rd,
    output logic [IW-1:0]     vec_idx,
    output logic              cpu_irq
);
    src_stat_t     stat [N];
    logic [N-1:0]  flag;
    lvl_t          lvl [N];
    logic [15:0]   word_rd [NUM_WORDS];
    logic          win_valid;
    logic [IW-1:0] win_idx;
    lvl_t          win_lvl;
    lvl_t          mask_q;
    logic          irq_q;
    logic          accept;

    logic unused_wbits;
    assign unused_wbits = ^{reg_wdata[12], reg_wdata[10:8], reg_wdata[4], reg_wdata[2:0]};

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic wsel;
        assign wsel = reg_wr && (reg_addr == AW'(w));
        for (genvar s = 0; s < 2; s++) begin : g_slot
            localparam int IDX = 2*w + s;
            irq_src_cell #(.LEVEL_TYPE(LEVEL_SRC[IDX])) u_cell (
                .clk     (clk),
                .rst     (rst),
                .req     (src_req[IDX]),
                .wr_en   (wsel),
                .wr_flag (slot_flag(reg_wdata, s)),
                .wr_lvl  (slot_lvl(reg_wdata, s)),
                .vec_clr (vec_rd && win_valid && (win_idx == IW'(IDX))),
                .flag    (flag[IDX]),
                .lvl     (lvl[IDX]),
                .stat    (stat[IDX])
            );
        end
        assign word_rd[w] = {pack_slot(flag[2*w+1], lvl[2*w+1]),
                             pack_slot(flag[2*w],   lvl[2*w])};
    end

    irq_resolver #(.N(N)) u_res (
        .stat      (stat),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_lvl   (win_lvl)
    );

    assign accept = win_valid && (mask_q > win_lvl);

    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '0;
        else if (mask_wr) mask_q <= mask_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)                   irq_q <= 1'b0;
        else if (vec_rd || mask_wr) irq_q <= 1'b0;
        else if (accept)           irq_q <= 1'b1;
    end

    assign reg_rdata = word_rd[reg_addr];
    assign vec_idx   = win_idx;
    assign cpu_irq   = irq_q;

    p_win_enabled_r2: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> (win_lvl != LVL_OFF));

    p_irq_cause_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> $past(win_valid && (mask_q > win_lvl)));

    p_irq_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (vec_rd || mask_wr) |=> !irq_q);
endmodule

// File: tb/irq_ctrl_test.sv
module irq_ctrl_test;
    localparam int NW = 4;
    localparam int N  = 8;
    localparam logic [N-1:0] LSRC = 8'hC0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] src_req = '0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic mask_wr = 1'b0;
    logic [2:0] mask_wdata = '0;
    logic vec_rd = 1'b0;
    logic [2:0] vec_idx;
    logic cpu_irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    bit [2:0] mlev [N];
    bit       mflag [N];
    bit [2:0] mmask;
    bit       mirq;

    always #4 clk = ~clk;

    irq_ctrl uut (
        .clk(clk), .rst(rst), .src_req(src_req), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mask_wr(mask_wr),
        .mask_wdata(mask_wdata), .vec_rd(vec_rd), .vec_idx(vec_idx), .cpu_irq(cpu_irq)
    );

    function automatic bit cur_flag(int i);
        return LSRC[i] ? src_req[i] : mflag[i];
    endfunction

    function automatic void winner(output bit v, output int idx, output bit [2:0] l);
        v = 0; idx = 0; l = 3'd7;
        for (int i = 0; i < N; i++)
            if (cur_flag(i) && mlev[i] < l) begin v = 1; idx = i; l = mlev[i]; end
    endfunction

    function automatic bit [15:0] exp_word(int w);
        return {mlev[2*w+1], 1'b0, cur_flag(2*w+1), 3'b000,
                mlev[2*w],   1'b0, cur_flag(2*w),   3'b000};
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_step();
        bit v; int wi; bit [2:0] wl;
        winner(v, wi, wl);
        if (rst) begin
            mirq = 0; mmask = 0;
            for (int i = 0; i < N; i++) begin mflag[i] = 0; mlev[i] = 3'd7; end
        end else begin
            if (vec_rd || mask_wr) mirq = 0;
            else if (v && mmask > wl) mirq = 1;
            for (int i = 0; i < N; i++) begin
                if (!LSRC[i]) begin
                    if (src_req[i]) mflag[i] = 1;
                    else if (reg_wr && reg_addr == i/2) mflag[i] = reg_wdata[(i%2)*8+3];
                    else if (vec_rd && v && wi == i) mflag[i] = 0;
                end
                if (reg_wr && reg_addr == i/2) mlev[i] = reg_wdata[(i%2)*8+5 +: 3];
            end
            if (mask_wr) mmask = mask_wdata;
        end
    endtask

    task automatic tick(string tag);
        bit v; int wi; bit [2:0] wl;
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(tag, "cpu_irq", cpu_irq, mirq);
        winner(v, wi, wl);
        if (v) check(tag, "vec_idx", vec_idx, wi);
        check(tag, "reg_rdata", reg_rdata, exp_word(reg_addr));
    endtask

    task automatic wr_word(int a, bit [15:0] d, string tag);
        reg_addr = a[1:0]; reg_wdata = d; reg_wr = 1;
        tick(tag);
        reg_wr = 0;
    endtask

    task automatic set_mask(bit [2:0] m, string tag);
        mask_wdata = m; mask_wr = 1;
        tick(tag);
        mask_wr = 0;
    endtask

    task automatic read_all(string tag);
        for (int a = 0; a < NW; a++) begin
            reg_addr = a[1:0];
            #1 check(tag, "word readback", reg_rdata, exp_word(a));
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240517));
        @(negedge clk);
        tick("R1"); tick("R1");
        rst = 0;
        @(negedge clk);
        check("R1", "cpu_irq after reset", cpu_irq, 0);
        for (int a = 0; a < NW; a++) begin
            reg_addr = a[1:0];
            #1 check("R1", "reset word", reg_rdata, 16'hE0E0);
        end
        // R6: source 0 flag + level 3, source 1 level 5 without flag
        wr_word(0, 16'hA068, "R6");
        read_all("R6");
        check("R6", "word0 layout", reg_rdata == 16'hA068 ? 1 : 0, 0); // reg_addr now 3
        reg_addr = 0; #1 check("R6", "word0 exact", reg_rdata, 16'hA068);
        // R3: mask equal to level blocks, one above accepts
        set_mask(3'd3, "R3");
        tick("R3"); check("R3", "mask==level blocks", cpu_irq, 0);
        set_mask(3'd4, "R3");
        check("R8", "low after mask write", cpu_irq, 0);
        tick("R3"); check("R3", "mask>level accepts", cpu_irq, 1);
        // R9: vector read clears winner flag, irq drops
        check("R4", "winner index", vec_idx, 0);
        vec_rd = 1; tick("R9"); vec_rd = 0;
        check("R8", "low after vec read", cpu_irq, 0);
        reg_addr = 0; #1 check("R9", "flag cleared", reg_rdata, 16'hA060);
        // R2: level 7 with flag set never requests
        set_mask(3'd7, "R2");
        wr_word(1, 16'hE0E8, "R2");
        tick("R2"); tick("R2"); check("R2", "disabled source", cpu_irq, 0);
        // R4: tie at level 2 between sources 2 and 3, lower index wins
        wr_word(1, 16'h4848, "R4");
        tick("R4"); check("R4", "tie lowest index", vec_idx, 2);
        wr_word(2, 16'h2800, "R4"); // source 5 level 1, flagged
        check("R4", "lower level wins", vec_idx, 5);
        // R5: pulse on edge source 4 sticks
        wr_word(2, 16'hE000, "R5");
        src_req[4] = 1; tick("R5"); src_req[4] = 0; tick("R5");
        reg_addr = 2; #1 check("R5", "sticky flag", reg_rdata[3], 1);
        // R5: set beats software clear in same cycle
        src_req[4] = 1; wr_word(2, 16'hE0E0, "R5"); src_req[4] = 0;
        reg_addr = 2; #1 check("R5", "set beats clear", reg_rdata[3], 1);
        // R7: level-type source 6 follows request; writes ignored
        wr_word(3, 16'hE008, "R7");
        reg_addr = 3; #1 check("R7", "write ignored", reg_rdata[3], 0);
        src_req[6] = 1; #1 check("R7", "follows req", reg_rdata[3], 1);
        wr_word(3, 16'hE000, "R7");
        reg_addr = 3; #1 check("R7", "clear ignored", reg_rdata[3], 1);
        src_req[6] = 0; #1 check("R7", "drops with req", reg_rdata[3], 0);
        // R8 and all: constrained random traffic against the model
        for (int c = 0; c < 3000; c++) begin
            src_req = (($urandom % 4) == 0) ? N'($urandom) & N'($urandom) : '0;
            reg_wr = ($urandom % 10) == 0;
            reg_addr = 2'($urandom);
            reg_wdata = 16'($urandom);
            mask_wr = ($urandom % 12) == 0;
            mask_wdata = 3'($urandom);
            vec_rd = ($urandom % 8) == 0;
            tick("R8");
        end
        src_req = '0; reg_wr = 0; mask_wr = 0; vec_rd = 0;
        tick("R8");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule